// File: doc/BRIEF.md
# Reloading 16-bit Down-Counter with Byte Register Port

The block is a 16-bit down-counter with a 16-bit reload latch, driven by an 8-bit register port. Software reaches the count value as two byte registers and a control byte selects one of four operating modes. When the counter holds zero, the next enabled count step reloads it from the latch and raises an underflow request. The count step comes from a one-cycle pulse `tick`. In the intended system that pulse is the system clock divided by 16 and is produced outside the block. In event mode the count step comes from edges of the external pin.

Wider values move through the byte port in a fixed order. To write, software writes the low byte first, which is only buffered, and then the high byte, which commits all 16 bits. To read, software reads the high byte first. That read freezes the matching low byte, so a later read of the low byte belongs to the same value even if the counter has moved on. A write-control bit chooses what a commit updates: both latch and counter, or the latch alone, in which case the counter takes the new value at its next reload.

The mode field is decoded into four named count-gating states. `MODE_TIMER` (00) counts every tick. `MODE_PULSE` (01) counts every tick and toggles the output pin on each underflow. `MODE_WIDTH` (10) counts ticks only while the synchronised pin is at its active level. `MODE_EVENT` (11) counts active pin edges and ignores ticks. The state changes only on a write to the control byte, and any of the four states can follow any other. A polarity bit sets the edge, level or starting output used by each mode. A separate edge request marks the trailing edge of an active pulse in `MODE_WIDTH`.

Top module: `rld_timer16`

## Requirements
- R1: After reset the counter and latch hold 16'hFFFF, the control byte and both flags are 0, and `pin_out` and `pin_oe` are 0.
- R2: In `MODE_TIMER` (control bits 1:0 = 00), each `tick` pulse lowers a non-zero counter by one.
- R3: An enabled count step while the counter is 0 reloads the counter from the latch and sets the underflow flag (flag byte at address 3, bit 0, also driven on `irq_uf`).
- R4: A write to address 0 (low byte) changes neither the counter nor the latch. A write to address 1 (high byte) commits {high, buffered low}. With write-control (control bit 4) at 0, the commit loads both latch and counter.
- R5: With write-control at 1, the commit loads only the latch. The counter keeps counting and picks up the new value at its next reload.
- R6: Reading address 1 returns the counter's high byte and freezes its low byte. A later read of address 0 returns that frozen byte, even after further counting.
- R7: While the stop bit (control bit 3) is 1, the counter does not change.
- R8: In `MODE_PULSE` (01), `pin_oe` is 1. A write to the control byte sets `pin_out` to the polarity bit (control bit 2), and every underflow toggles `pin_out`.
- R9: In `MODE_WIDTH` (10), ticks count only while the synchronised pin equals the active level: high when the polarity bit is 0, low when it is 1.
- R10: In `MODE_EVENT` (11), the counter steps once per active pin edge (rising for polarity 0, falling for polarity 1), and `tick` has no effect.
- R11: In `MODE_WIDTH`, the trailing edge of an active pulse sets the edge flag (flag byte bit 1, driven on `irq_edge`). In other modes pin edges leave it clear.
- R12: Writing 1 to a flag bit clears that flag and writing 0 leaves it. If an underflow occurs in the same cycle as a clear of the underflow flag, the flag ends up set.
- R13: If a commit with write-control 0 falls in the same cycle as a count step, the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 low, 1 high, 2 control, 3 flags |
| wr_stb | input | 1 | Write strobe, one cycle |
| rd_stb | input | 1 | Read strobe, one cycle (needed for the high-byte freeze) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| tick | input | 1 | Prescaled count pulse |
| pin_in | input | 1 | External pin level, asynchronous |
| pin_out | output | 1 | Pulse output level |
| pin_oe | output | 1 | Output enable for the pin, high in `MODE_PULSE` |
| irq_uf | output | 1 | Underflow request flag |
| irq_edge | output | 1 | Pulse-trailing-edge request flag |

## Verification
Two pairs of actions can fall in the same cycle and need a fixed priority. The first pair is a register write to the counter and a count step. The second pair is a write-1 clear of the underflow flag and an underflow that sets it. The bench provokes each pair by asserting `tick` in the same cycle as the strobe of the colliding write. It then judges the result from the ports: the counter must read back the written value with no decrement applied, and `irq_uf` must still be high after the clear. A sweep over start values, latch values and tick counts, with expected counts computed in the bench, covers the reload path around zero.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_PULSE = 2'b01,
        MODE_WIDTH = 2'b10,
        MODE_EVENT = 2'b11
    } rt_mode_e;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_LO   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd3;

    // control byte field positions
    localparam int CB_POL  = 2;
    localparam int CB_STOP = 3;
    localparam int CB_WCTL = 4;
    localparam int CTRL_W  = 5;

endpackage

// File: rtl/rt_pin_sync.sv
module rt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], pin_i};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign lvl_o  = sh_q[STAGES-1];
    assign rise_o = sh_q[STAGES-1] & ~prev_q;
    assign fall_o = ~sh_q[STAGES-1] & prev_q;

endmodule

// File: rtl/rt_gate.sv
module rt_gate
    import rt_pkg::*;
(
    input  rt_mode_e mode_i,
    input  logic     stop_i,
    input  logic     pol_i,
    input  logic     tick_i,
    input  logic     lvl_i,
    input  logic     rise_i,
    input  logic     fall_i,
    output logic     dec_o,
    output logic     trail_o
);
    logic act_lvl;
    logic act_edge;
    logic end_edge;

    always_comb begin
        act_lvl  = lvl_i ^ pol_i;
        act_edge = pol_i ? fall_i : rise_i;
        end_edge = pol_i ? rise_i : fall_i;
        dec_o    = 1'b0;
        trail_o  = 1'b0;
        unique case (mode_i)
            MODE_TIMER: dec_o = tick_i & ~stop_i;
            MODE_PULSE: dec_o = tick_i & ~stop_i;
            MODE_WIDTH: begin
                dec_o   = tick_i & ~stop_i & act_lvl;
                trail_o = end_edge;
            end
            MODE_EVENT: dec_o = act_edge & ~stop_i;
        endcase
    end

endmodule

// File: rtl/rt_count_core.sv
module rt_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_latch,
    input  logic             ld_count,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             dec_en,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] latch_o,
    output logic             uf_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] latch_q;

    assign uf_o = dec_en && !ld_count && (count_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '1;
            latch_q <= '1;
        end else begin
            if (ld_latch) latch_q <= ld_val;
            if (ld_count) begin
                count_q <= ld_val;
            end else if (dec_en) begin
                if (count_q == '0) count_q <= latch_q;
                else               count_q <= count_q - ONE;
            end
        end
    end

    assign count_o = count_q;
    assign latch_o = latch_q;

    assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !ld_count && count_q != '0) |=> count_q == $past(count_q) - ONE);

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        uf_o |=> count_q == $past(latch_q));

    assert_wr_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ld_count |=> count_q == $past(ld_val));

endmodule

// File: rtl/rld_timer16.sv
module rld_timer16
    import rt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq_uf,
    output logic              irq_edge
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] lo_buf_q;
    logic [DATA_W-1:0] snap_q;
    logic              uf_flag_q;
    logic              edge_flag_q;
    logic              pout_q;

    rt_mode_e          mode;
    logic              wr_lo, wr_hi, wr_ctrl, wr_flag;
    logic              ld_count;
    logic [CNT_W-1:0]  ld_val;
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  latch_w;
    logic              uf_w;
    logic              dec_w;
    logic              trail_w;
    logic              lvl_w, rise_w, fall_w;

    assign mode     = rt_mode_e'(ctrl_q[1:0]);
    assign wr_lo    = wr_stb && (addr == ADR_LO);
    assign wr_hi    = wr_stb && (addr == ADR_HI);
    assign wr_ctrl  = wr_stb && (addr == ADR_CTRL);
    assign wr_flag  = wr_stb && (addr == ADR_FLAG);
    assign ld_count = wr_hi && !ctrl_q[CB_WCTL];
    assign ld_val   = {wdata, lo_buf_q};

    rt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .lvl_o  (lvl_w),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    rt_gate u_gate (
        .mode_i  (mode),
        .stop_i  (ctrl_q[CB_STOP]),
        .pol_i   (ctrl_q[CB_POL]),
        .tick_i  (tick),
        .lvl_i   (lvl_w),
        .rise_i  (rise_w),
        .fall_i  (fall_w),
        .dec_o   (dec_w),
        .trail_o (trail_w)
    );

    rt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_latch (wr_hi),
        .ld_count (ld_count),
        .ld_val   (ld_val),
        .dec_en   (dec_w),
        .count_o  (cnt_w),
        .latch_o  (latch_w),
        .uf_o     (uf_w)
    );

    // register port state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            lo_buf_q <= '0;
            snap_q   <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
            if (wr_lo)   lo_buf_q <= wdata;
            if (rd_stb && addr == ADR_HI) snap_q <= cnt_w[DATA_W-1:0];
        end
    end

    // flags: a new event outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uf_flag_q   <= 1'b0;
            edge_flag_q <= 1'b0;
        end else begin
            uf_flag_q   <= (uf_flag_q   & ~(wr_flag & wdata[0])) | uf_w;
            edge_flag_q <= (edge_flag_q & ~(wr_flag & wdata[1])) | trail_w;
        end
    end

    // pulse output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pout_q <= 1'b0;
        end else if (wr_ctrl) begin
            pout_q <= wdata[CB_POL];
        end else if (mode == MODE_PULSE && uf_w) begin
            pout_q <= ~pout_q;
        end
    end

    always_comb begin
        unique case (addr)
            ADR_LO:   rdata = snap_q;
            ADR_HI:   rdata = cnt_w[CNT_W-1:DATA_W];
            ADR_CTRL: rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            ADR_FLAG: rdata = {{(DATA_W-2){1'b0}}, edge_flag_q, uf_flag_q};
        endcase
    end

    assign pin_out  = pout_q;
    assign pin_oe   = (mode == MODE_PULSE);
    assign irq_uf   = uf_flag_q;
    assign irq_edge = edge_flag_q;

    assert_lo_buffered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> $stable(latch_w));

    assert_stop_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_STOP] && !wr_stb) |=> $stable(cnt_w));

    assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PULSE && uf_w && !wr_ctrl) |=> pin_out != $past(pin_out));

    assert_flag_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        uf_w |=> irq_uf);

endmodule

// File: tb/test_rld_timer16.sv
module test_rld_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tick = 1'b0;
    logic       pin_in = 1'b0;
    logic       pin_out, pin_oe, irq_uf, irq_edge;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    rld_timer16 i_rld_timer16 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .rdata(rdata), .tick(tick), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_uf(irq_uf), .irq_edge(irq_edge)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic t);
        @(negedge clk);
        addr = a; wdata = d; wr_stb = 1'b1; tick = t;
        @(negedge clk);
        wr_stb = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] h, l;
        rd(2'd1, h);
        rd(2'd0, l);
        v = {h, l};
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic setctrl(input logic [1:0] m, input logic pol, input logic stop, input logic wctl);
        wr(2'd2, {3'b000, wctl, stop, pol, m}, 1'b0);
    endtask

    // counter = v, latch = l; leaves timer mode with write-control 1
    task automatic load(input logic [15:0] v, input logic [15:0] l);
        setctrl(2'b00, 1'b0, 1'b0, 1'b0);
        wr(2'd0, v[7:0], 1'b0);
        wr(2'd1, v[15:8], 1'b0);
        setctrl(2'b00, 1'b0, 1'b0, 1'b1);
        wr(2'd0, l[7:0], 1'b0);
        wr(2'd1, l[15:8], 1'b0);
    endtask

    task automatic pin_set(input logic b);
        @(negedge clk); pin_in = b;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [15:0] model_cnt(input logic [15:0] v, input logic [15:0] l, input int n);
        logic [15:0] c = v;
        for (int i = 0; i < n; i++) c = (c == 16'h0) ? l : c - 16'h1;
        return c;
    endfunction

    function automatic logic model_uf(input logic [15:0] v, input int n);
        return (n > int'(v));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v16;
        logic [7:0]  b;
        logic [15:0] vals [5];
        logic [15:0] lats [2];
        vals = '{16'h0000, 16'h0001, 16'h0002, 16'h0005, 16'h0100};
        lats = '{16'h0003, 16'h0100};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd16(v16);       chk("R1 counter", v16, 16'hFFFF);
        rd(2'd2, b);     chk("R1 control", b, 8'h00);
        rd(2'd3, b);     chk("R1 flags", b, 8'h00);
        chk("R1 pin_out", pin_out, 1'b0);
        chk("R1 pin_oe", pin_oe, 1'b0);

        // R4 low byte is only buffered
        wr(2'd0, 8'h34, 1'b0);
        rd16(v16);       chk("R4 low write no effect", v16, 16'hFFFF);
        wr(2'd1, 8'h12, 1'b0);
        rd16(v16);       chk("R4 commit both", v16, 16'h1234);

        // R2/R3 sweep over start, latch and tick count
        foreach (vals[vi]) foreach (lats[li]) for (int n = 0; n < 7; n++) begin
            load(vals[vi], lats[li]);
            wr(2'd3, 8'h03, 1'b0);
            ticks(n);
            rd16(v16);
            chk("R2/R3 count", v16, model_cnt(vals[vi], lats[li], n));
            chk("R3 flag", irq_uf, model_uf(vals[vi], n));
        end

        // R5 latch-only write
        load(16'h0005, 16'h0009);
        rd16(v16);       chk("R5 counter kept", v16, 16'h0005);
        ticks(6);
        rd16(v16);       chk("R5 reload new latch", v16, 16'h0009);

        // R6 high-first read freezes low byte
        load(16'h0100, 16'h0100);
        rd(2'd1, b);     chk("R6 high byte", b, 8'h01);
        ticks(1);
        rd(2'd0, b);     chk("R6 frozen low", b, 8'h00);
        rd16(v16);       chk("R6 fresh pair", v16, 16'h00FF);

        // R7 stop
        load(16'h0040, 16'h0040);
        setctrl(2'b00, 1'b0, 1'b1, 1'b1);
        ticks(5);
        rd16(v16);       chk("R7 stopped", v16, 16'h0040);

        // R8 pulse output, both polarities
        load(16'h0002, 16'h0002);
        setctrl(2'b01, 1'b0, 1'b0, 1'b1);
        chk("R8 oe", pin_oe, 1'b1);
        chk("R8 start pol0", pin_out, 1'b0);
        ticks(3);        chk("R8 toggle 1", pin_out, 1'b1);
        ticks(3);        chk("R8 toggle 2", pin_out, 1'b0);
        ticks(2);        chk("R8 no early toggle", pin_out, 1'b0);
        setctrl(2'b01, 1'b1, 1'b0, 1'b1);
        chk("R8 start pol1", pin_out, 1'b1);
        setctrl(2'b00, 1'b0, 1'b0, 1'b1);
        chk("R8 oe off", pin_oe, 1'b0);

        // R9/R11 width mode, polarity 0
        load(16'd100, 16'd100);
        wr(2'd3, 8'h03, 1'b0);
        setctrl(2'b10, 1'b0, 1'b0, 1'b1);
        ticks(5);
        rd16(v16);       chk("R9 idle level", v16, 16'd100);
        pin_set(1'b1);
        ticks(5);
        rd16(v16);       chk("R9 active high", v16, 16'd95);
        chk("R11 no flag on leading edge", irq_edge, 1'b0);
        pin_set(1'b0);
        chk("R11 trailing edge flag", irq_edge, 1'b1);
        ticks(3);
        rd16(v16);       chk("R9 inactive again", v16, 16'd95);

        // R9/R11 width mode, polarity 1 (pin low is active)
        wr(2'd3, 8'h02, 1'b0);
        chk("R12 edge flag clear", irq_edge, 1'b0);
        setctrl(2'b10, 1'b1, 1'b0, 1'b1);
        ticks(2);
        rd16(v16);       chk("R9 active low", v16, 16'd93);
        pin_set(1'b1);
        chk("R11 trailing edge pol1", irq_edge, 1'b1);
        ticks(2);
        rd16(v16);       chk("R9 high inactive pol1", v16, 16'd93);
        pin_set(1'b0);

        // R10/R11 event mode
        load(16'd50, 16'd50);
        wr(2'd3, 8'h03, 1'b0);
        setctrl(2'b11, 1'b0, 1'b0, 1'b1);
        ticks(4);
        rd16(v16);       chk("R10 tick ignored", v16, 16'd50);
        for (int k = 0; k < 3; k++) begin pin_set(1'b1); pin_set(1'b0); end
        rd16(v16);       chk("R10 rising edges", v16, 16'd47);
        chk("R11 no flag in event mode", irq_edge, 1'b0);
        setctrl(2'b11, 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin pin_set(1'b1); pin_set(1'b0); end
        rd16(v16);       chk("R10 falling edges", v16, 16'd44);

        // R12 clear versus simultaneous underflow
        load(16'h0000, 16'h0005);
        wr(2'd3, 8'h03, 1'b0);
        chk("R12 cleared", irq_uf, 1'b0);
        wr(2'd3, 8'h01, 1'b1);
        chk("R12 set beats clear", irq_uf, 1'b1);
        rd16(v16);       chk("R12 reload value", v16, 16'h0005);
        wr(2'd3, 8'h02, 1'b0);
        chk("R12 write 0 keeps", irq_uf, 1'b1);
        wr(2'd3, 8'h01, 1'b0);
        chk("R12 write 1 clears", irq_uf, 1'b0);

        // R13 commit collides with a count step
        load(16'd10, 16'd10);
        setctrl(2'b00, 1'b0, 1'b0, 1'b0);
        wr(2'd0, 8'h77, 1'b0);
        wr(2'd1, 8'h00, 1'b1);
        rd16(v16);       chk("R13 write wins", v16, 16'h0077);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule